// File: doc/BRIEF.md
# ATA Task-File Register Unit

This block is the host-facing command register file of an ATA disk target. A host reaches it through eight byte-wide offsets. It writes the sector count, the three address bytes and the device byte, and it issues commands through the command offset. It follows progress through the status byte, the error byte and a single interrupt line. Storage media and bus-master DMA sit outside the block.

The unit runs two commands itself. IDENTIFY streams a 256-word identity block over the 16-bit data port. FLUSH CACHE holds the unit busy until a backend pulses a completion input, so the busy phase lasts as long as the backend takes. Any other command code is rejected with an abort error.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, status reads 0x40 and the interrupt is low. Offsets 1 to 6 all read 0.
- R2: Byte writes to offsets 2 (sector count), 3, 4 and 5 (address low, mid and high) and 6 (device: bit 4 picks unit 1, bit 6 picks block addressing) read back unchanged. Offset 0 is data, offset 1 is error on read and feature on write, and offset 7 is status on read and command on write.
- R3: The status byte has busy at bit 7, ready at bit 6 (always 1), device fault at bit 5 (always 0), data request at bit 3 and error at bit 0. All other bits read 0.
- R4: Writing 0xEC to offset 7 makes status read 0x48 from the next cycle and raises the interrupt.
- R5: During IDENTIFY, successive reads of offset 0 return the words in index order. Word 0 is 0x0040 and word 85 is 0x0020 (write cache on). Words 10 to 19 hold the serial "ATATF0001" padded with spaces to 20 characters. Words 23 to 26 hold the firmware text "REV1.0" padded to 8 characters. Each word carries its first character in the high byte. Every other word is 0.
- R6: The cycle after the 256th data read, status reads 0x40. A read of offset 0 with no transfer running returns 0.
- R7: Writing 0xE7 makes status read 0xC0 until the cycle after a `flush_done` pulse. From that cycle status reads 0x40 and the interrupt is high. A pulse on `flush_done` while the unit is not busy has no effect.
- R8: A read of offset 7 lowers the interrupt from the next cycle.
- R9: A write to offset 7 while busy is ignored.
- R10: Any command code other than 0xEC or 0xE7 gives status 0x41 and error 0x04 on the next cycle, and raises the interrupt.
- R11: An accepted command clears the error bit and the error byte, and ends any IDENTIFY transfer in progress.
- R12: A write to offset 1 does not change the value read back from offset 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe for the offset |
| wdata | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe (carries the side effects of a read) |
| flush_done | input | 1 | One-cycle pulse from the backend ending a flush |
| rdata | output | 16 | Read data for the offset |
| irq | output | 1 | Interrupt request |

## Verification
A behavioural model predicts the read data and the interrupt every cycle. The model and the design are driven by the same sequences:
- Register write/read sweeps check the address decode.
- A rejected command followed by IDENTIFY shows that a new command clears an earlier error.
- A full 256-word IDENTIFY checks word order and content. An IDENTIFY cut short by a flush checks that a new command ends the transfer.
- Flushes with a long backend delay and with a one-cycle delay check that busy lasts exactly as long as the backend holds it.
- Commands issued while busy, and completion pulses sent while idle, must leave the state unchanged.

// File: rtl/ata_taskfile.sv
module ata_taskfile #(
  parameter int          ID_WORDS   = 256,
  parameter logic [159:0] SERIAL_STR = "ATATF0001           ",
  parameter logic [63:0]  FW_STR     = "REV1.0  ",
  parameter logic [7:0]   CMD_IDENT  = 8'hEC,
  parameter logic [7:0]   CMD_FLUSH  = 8'hE7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  input  logic        rd_en,
  input  logic        flush_done,
  output logic [15:0] rdata,
  output logic        irq
);
  localparam int IW = $clog2(ID_WORDS);
  localparam logic [IW-1:0] LAST = IW'(ID_WORDS - 1);
  localparam logic [2:0] A_DATA = 3'd0, A_ERR = 3'd1, A_CNT = 3'd2, A_LO = 3'd3,
                         A_MID = 3'd4, A_HI = 3'd5, A_DEV = 3'd6, A_CMD = 3'd7;
  localparam logic [7:0] ABORT_CODE = 8'h04;

  logic [7:0]    cnt_q, lo_q, mid_q, hi_q, dev_q, errreg_q;
  logic          bsy_q, drq_q, err_q, irq_q;
  logic [IW-1:0] idx_q;
  logic [15:0]   id_word;
  logic [7:0]    status;
  int            idx_i;

  assign idx_i  = int'(idx_q);
  assign status = {bsy_q, 1'b1, 1'b0, 1'b0, drq_q, 2'b00, err_q};
  assign irq    = irq_q;

  always_comb begin
    id_word = '0;
    if (idx_i == 0)
      id_word = 16'h0040;
    else if (idx_i >= 10 && idx_i < 20)
      id_word = SERIAL_STR[159 - 16*(idx_i - 10) -: 16];
    else if (idx_i >= 23 && idx_i < 27)
      id_word = FW_STR[63 - 16*(idx_i - 23) -: 16];
    else if (idx_i == 85)
      id_word = 16'h0020;
  end

  always_comb begin
    case (addr)
      A_DATA:  rdata = drq_q ? id_word : 16'h0000;
      A_ERR:   rdata = {8'h00, errreg_q};
      A_CNT:   rdata = {8'h00, cnt_q};
      A_LO:    rdata = {8'h00, lo_q};
      A_MID:   rdata = {8'h00, mid_q};
      A_HI:    rdata = {8'h00, hi_q};
      A_DEV:   rdata = {8'h00, dev_q};
      default: rdata = {8'h00, status};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0; lo_q <= '0; mid_q <= '0; hi_q <= '0; dev_q <= '0;
      errreg_q <= '0; bsy_q <= 1'b0; drq_q <= 1'b0; err_q <= 1'b0;
      irq_q <= 1'b0; idx_q <= '0;
    end else begin
      if (rd_en && addr == A_DATA && drq_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST) drq_q <= 1'b0;
      end
      if (rd_en && addr == A_CMD) irq_q <= 1'b0;
      if (bsy_q && flush_done) begin
        bsy_q <= 1'b0;
        irq_q <= 1'b1;
      end
      if (wr_en) begin
        case (addr)
          A_CNT: cnt_q <= wdata;
          A_LO:  lo_q  <= wdata;
          A_MID: mid_q <= wdata;
          A_HI:  hi_q  <= wdata;
          A_DEV: dev_q <= wdata;
          A_CMD: if (!bsy_q) begin
            err_q    <= 1'b0;
            errreg_q <= '0;
            drq_q    <= 1'b0;
            idx_q    <= '0;
            if (wdata == CMD_IDENT) begin
              drq_q <= 1'b1;
              irq_q <= 1'b1;
            end else if (wdata == CMD_FLUSH) begin
              bsy_q <= 1'b1;
            end else begin
              err_q    <= 1'b1;
              errreg_q <= ABORT_CODE;
              irq_q    <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_q |-> !drq_q);

  // R9
  cmd_busy_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CMD && bsy_q && !flush_done) |=> (bsy_q && !drq_q));

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CMD && !wr_en && !(bsy_q && flush_done)) |=> !irq_q);

  // R6
  ident_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_DATA && drq_q && idx_q == LAST && !wr_en) |=> (!drq_q && !bsy_q));

  // R7
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy_q && !flush_done) |=> bsy_q);

  // R10
  unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CMD && !bsy_q && wdata != CMD_IDENT && wdata != CMD_FLUSH)
      |=> (err_q && irq_q && errreg_q == ABORT_CODE && !bsy_q));
endmodule

// File: tb/ata_taskfile_test.sv
`timescale 1ns/1ps
module ata_taskfile_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, flush_done = 1'b0;
  logic [7:0]  wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  ata_taskfile uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
                    .rd_en(rd_en), .flush_done(flush_done), .rdata(rdata), .irq(irq));

  // behavioural reference
  logic [7:0]  m_reg [8];
  logic [7:0]  m_err;
  bit          m_bsy, m_drq, m_errbit, m_irq;
  logic [15:0] idq[$];

  function automatic logic [15:0] id_exp(int i);
    string ser = "ATATF0001           ";
    string fw  = "REV1.0  ";
    if (i == 0) return 16'h0040;
    if (i >= 10 && i < 20) return {ser[2*(i-10)], ser[2*(i-10)+1]};
    if (i >= 23 && i < 27) return {fw[2*(i-23)], fw[2*(i-23)+1]};
    if (i == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] exp_rd(logic [2:0] a);
    if (a == 3'd0) return (m_drq && idq.size() > 0) ? idq[0] : 16'h0000;
    if (a == 3'd1) return {8'h00, m_err};
    if (a == 3'd7) return {8'h00, m_bsy, 1'b1, 1'b0, 1'b0, m_drq, 2'b00, m_errbit};
    return {8'h00, m_reg[a]};
  endfunction

  always @(posedge clk) begin
    bit b0;
    b0 = m_bsy;
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 8'h00;
      m_err = 0; m_bsy = 0; m_drq = 0; m_errbit = 0; m_irq = 0; idq.delete();
    end else begin
      if (rd_en && addr == 3'd0 && m_drq) begin
        void'(idq.pop_front());
        if (idq.size() == 0) m_drq = 0;
      end
      if (rd_en && addr == 3'd7) m_irq = 0;
      if (b0 && flush_done) begin m_bsy = 0; m_irq = 1; end
      if (wr_en) begin
        if (addr >= 3'd2 && addr <= 3'd6) m_reg[addr] = wdata;
        else if (addr == 3'd7 && !b0) begin
          m_errbit = 0; m_err = 0; m_drq = 0; idq.delete();
          if (wdata == 8'hEC) begin
            for (int i = 0; i < 256; i++) idq.push_back(id_exp(i));
            m_drq = 1; m_irq = 1;
          end else if (wdata == 8'hE7) m_bsy = 1;
          else begin m_errbit = 1; m_err = 8'h04; m_irq = 1; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      compared++;
      if (irq !== m_irq) begin
        mismatched++;
        $display("FAIL R8 irq per-cycle: actual %0b expected %0b", irq, m_irq);
      end
      if (rd_en) begin
        logic [15:0] e;
        e = exp_rd(addr);
        compared++;
        if (rdata !== e) begin
          mismatched++;
          $display("FAIL %s per-cycle offset %0d: actual %h expected %h",
                   addr == 0 ? "R5" : addr == 7 ? "R3" : addr == 1 ? "R10" : "R2", addr, rdata, e);
        end
      end
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(bit w, bit r, logic [2:0] a, logic [7:0] d, output logic [15:0] q);
    @(posedge clk); #1;
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(negedge clk); q = rdata;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    logic [15:0] q;
    access(1, 0, a, d, q);
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] q);
    access(0, 1, a, 8'h00, q);
  endtask

  task automatic pulse_done();
    @(posedge clk); #1 flush_done = 1;
    @(posedge clk); #1 flush_done = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] q;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;

    rd(3'd7, q); chk("R1 status", q, 16'h0040);
    chk("R1 irq", {15'h0, irq}, 16'h0000);
    for (int a = 1; a < 7; a++) begin rd(3'(a), q); chk("R1 reg", q, 16'h0000); end

    wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33); wr(3'd5, 8'h44); wr(3'd6, 8'h50);
    rd(3'd2, q); chk("R2 count", q, 16'h0011);
    rd(3'd3, q); chk("R2 low", q, 16'h0022);
    rd(3'd4, q); chk("R2 mid", q, 16'h0033);
    rd(3'd5, q); chk("R2 high", q, 16'h0044);
    rd(3'd6, q); chk("R2 device", q, 16'h0050);

    wr(3'd1, 8'h5A); rd(3'd1, q); chk("R12 feature write", q, 16'h0000);

    wr(3'd7, 8'h77);
    chk("R10 irq", {15'h0, irq}, 16'h0001);
    rd(3'd1, q); chk("R10 error", q, 16'h0004);
    rd(3'd7, q); chk("R10 status", q, 16'h0041);
    chk("R8 irq cleared", {15'h0, irq}, 16'h0000);
    wr(3'd1, 8'hFF); rd(3'd1, q); chk("R12 error kept", q, 16'h0004);

    wr(3'd7, 8'hEC);
    chk("R4 irq", {15'h0, irq}, 16'h0001);
    rd(3'd1, q); chk("R11 error cleared", q, 16'h0000);
    rd(3'd7, q); chk("R4 status", q, 16'h0048);
    chk("R8 irq cleared", {15'h0, irq}, 16'h0000);
    for (int i = 0; i < 256; i++) begin
      rd(3'd0, q); chk("R5 word", q, id_exp(i));
      if (i == 85) chk("R5 cache bit", q & 16'h0020, 16'h0020);
      if (i == 10) chk("R5 serial", q, 16'h4154);
    end
    rd(3'd7, q); chk("R6 status end", q, 16'h0040);
    rd(3'd0, q); chk("R6 idle data", q, 16'h0000);

    wr(3'd7, 8'hE7);
    repeat (5) @(posedge clk);
    rd(3'd7, q); chk("R7 busy", q, 16'h00C0);
    chk("R7 no irq while busy", {15'h0, irq}, 16'h0000);
    wr(3'd7, 8'hEC);
    rd(3'd7, q); chk("R9 ignored", q, 16'h00C0);
    rd(3'd0, q); chk("R9 no data", q, 16'h0000);
    pulse_done();
    chk("R7 irq", {15'h0, irq}, 16'h0001);
    rd(3'd7, q); chk("R7 done", q, 16'h0040);

    pulse_done();
    chk("R7 idle pulse", {15'h0, irq}, 16'h0000);
    rd(3'd7, q); chk("R7 idle pulse status", q, 16'h0040);

    wr(3'd7, 8'hEC);
    rd(3'd0, q); chk("R5 word0", q, 16'h0040);
    rd(3'd0, q); chk("R5 word1", q, 16'h0000);
    wr(3'd7, 8'hE7);
    @(posedge clk); #1 flush_done = 1;
    @(negedge clk); chk("R11 transfer ended", rdata & 16'h0008, 16'h0000);
    @(posedge clk); #1 flush_done = 0;
    rd(3'd7, q); chk("R7 short flush", q, 16'h0040);
    rd(3'd0, q); chk("R11 no data", q, 16'h0000);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule